// File: doc/BRIEF.md
# Standby-Aware Parallel I/O Port

This block controls one parallel port of general-purpose pins from a simple peripheral register bus. Two registers are visible on the bus. The direction register is write-only, and each of its bits sets one pin to drive (1) or to float as an input (0). The output latch is read/write and holds the level that driving pins present. Reads of the latch address are merged per bit: a driving pin returns its latch bit, and a floating pin returns its pin level after a synchronizer.

Three control inputs govern register state. Reset and hardware standby each clear both registers. Software standby freezes both registers, so pins that were driving keep driving their values. An alternate pattern-output source may take over a pin's output value. That pin is still only driven while its direction bit is 1.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset (rst_n low, asynchronous) pin_oe, pin_out and bus_rdata are all zero, and both registers are zero.
- R2: A write with bus_wr high and bus_addr = 0 (direction register) updates the direction register at that clock edge. When neither standby is active, pin_oe shows the written value from the next cycle onward.
- R3: A read with bus_addr = 0 returns 0xFF, whatever the direction register holds.
- R4: A write with bus_addr = 1 (output latch) stores the data. A read of address 1 with every direction bit at 1 returns the stored latch.
- R5: On a read of address 1, bit i returns the latch bit when direction bit i is 1 and the synchronized pin level when it is 0. The pin level passes through two flops, so a pin change applied before edge e is first returned by a read strobed at edge e+2.
- R6: While hw_stby is high, both registers are cleared at every clock edge and writes are discarded. pin_oe and the latch contribution to pin_out are zero from the next cycle.
- R7: While sw_stby is high (and hw_stby is low), writes are discarded and both registers keep their values, so pin_oe and pin_out stay unchanged. Reads still work.
- R8: pin_oe equals the direction register. Bit i of pin_out is alt_data[i] when alt_en[i] is 1 and the latch bit otherwise.
- R9: A read of any address other than 0 or 1 returns 0x00, and bus_rdata is 0x00 in any cycle that follows a cycle without a read strobe.
- R10: Read data is valid exactly one cycle after the cycle in which bus_rd is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: clears registers |
| sw_stby | input | 1 | Software standby: freezes registers |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Pin levels from the pads |
| alt_en | input | WIDTH | Per-pin alternate output select |
| alt_data | input | WIDTH | Alternate output values |
| pin_out | output | WIDTH | Pin output values |
| pin_oe | output | WIDTH | Pin output enables |

## Verification
Register writes and standby effects reach pin_oe and pin_out one cycle after the strobe edge. Read data appears one cycle after the read strobe. Pin levels reach read data two edges after they change, plus the one-cycle read latency. The bench drives inputs at the falling edge, so the directed checks sample at the next falling edge after a register update. A behavioural model advances at each rising edge and is compared a quarter period later on every cycle. The synchronizer test issues back-to-back reads and expects the old level twice before the new one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_DAT  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_stby,
    input  logic             sw_stby,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_o,
    output logic [WIDTH-1:0] lat_o
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (hw_stby) begin
            regs_d = '0;
        end else if (wr_en && !sw_stby) begin
            unique case (wr_sel)
                SEL_DIR: regs_d.dir = wr_data;
                SEL_DAT: regs_d.lat = wr_data;
                default: regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir_o = regs_q.dir;
    assign lat_o = regs_q.lat;

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  reg_sel_e         rd_sel,
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] lat_i,
    input  logic [WIDTH-1:0] pin_sync_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] rdata_d, rdata_q;
    logic [WIDTH-1:0] merged;

    always_comb begin
        merged = (dir_i & lat_i) | (~dir_i & pin_sync_i);
        rdata_d = '0;
        if (rd_en) begin
            unique case (rd_sel)
                SEL_DIR: rdata_d = '1;
                SEL_DAT: rdata_d = merged;
                default: rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
    import gpio_port_pkg::*;
#(
    parameter int          WIDTH       = 8,
    parameter int          ADDR_W      = 4,
    parameter int          SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DIR_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    input  logic [WIDTH-1:0]  alt_en,
    input  logic [WIDTH-1:0]  alt_data,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] dir_w, lat_w, pin_sync_w;

    always_comb begin
        if (bus_addr == DIR_ADDR)      sel = SEL_DIR;
        else if (bus_addr == DAT_ADDR) sel = SEL_DAT;
        else                           sel = SEL_NONE;
    end

    gpio_port_regs #(.WIDTH(WIDTH)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .wr_en   (bus_wr),
        .wr_sel  (sel),
        .wr_data (bus_wdata),
        .dir_o   (dir_w),
        .lat_o   (lat_w)
    );

    gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync_w)
    );

    gpio_port_rdmux #(.WIDTH(WIDTH)) rdmux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (bus_rd),
        .rd_sel     (sel),
        .dir_i      (dir_w),
        .lat_i      (lat_w),
        .pin_sync_i (pin_sync_w),
        .rdata_o    (bus_rdata)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pin_out[i] = alt_en[i] ? alt_data[i] : lat_w[i];
        assign pin_oe[i]  = dir_w[i];
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] DIR_ADDR = 4'h0,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 4'h1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_stby,
    input logic              sw_stby,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pin_oe
);

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_ADDR && !hw_stby && !sw_stby) |=> (pin_oe == $past(bus_wdata))); // R2

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_stby && !(bus_wr && bus_addr == DIR_ADDR)) |=> $stable(pin_oe)); // R2

    AST_DIR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DIR_ADDR) |=> (bus_rdata == '1)); // R3

    AST_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (pin_oe == '0)); // R6

    AST_SW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby) |=> $stable(pin_oe)); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != DIR_ADDR && bus_addr != DAT_ADDR) |=> (bus_rdata == '0)); // R9

endmodule

bind gpio_port_ctl gpio_port_chk #(
    .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_oe(pin_oe)
);

// File: tb/gpio_port_ctl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctl_tb_top;

    localparam int CLK_P = 10;
    localparam int W     = 8;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         hw_stby = 0, sw_stby = 0, bus_wr = 0, bus_rd = 0;
    logic [3:0]   bus_addr = 0;
    logic [W-1:0] bus_wdata = 0, pin_in = 8'h3C, alt_en = 0, alt_data = 0;
    logic [W-1:0] bus_rdata, pin_out, pin_oe;

    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_port_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .alt_en(alt_en), .alt_data(alt_data), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_dir = 0, m_lat = 0, m_s1 = 0, m_s2 = 0, m_rd = 0;

    always @(posedge clk) begin
        int nxt_rd;
        logic [W-1:0] exp_out;
        if (!rst_n) begin
            m_dir = 0; m_lat = 0; m_s1 = 0; m_s2 = 0; m_rd = 0;
        end else begin
            nxt_rd = 0;
            if (bus_rd) begin
                if (bus_addr == 0)      nxt_rd = 'hFF;
                else if (bus_addr == 1) nxt_rd = ((m_dir & m_lat) | (~m_dir & m_s2)) & 'hFF;
            end
            m_s2 = m_s1;
            m_s1 = int'(pin_in);
            if (hw_stby) begin
                m_dir = 0; m_lat = 0;
            end else if (bus_wr && !sw_stby) begin
                if (bus_addr == 0) m_dir = int'(bus_wdata);
                if (bus_addr == 1) m_lat = int'(bus_wdata);
            end
            m_rd = nxt_rd;
        end
        #(CLK_P/4);
        if (rst_n) begin
            for (int i = 0; i < W; i++)
                exp_out[i] = alt_en[i] ? alt_data[i] : m_lat[i];
            chk("R8 model pin_oe", pin_oe, m_dir[W-1:0]);
            chk("R8 model pin_out", pin_out, exp_out);
            chk("R10 model rdata", bus_rdata, m_rd[W-1:0]);
        end
    end

    task automatic wr(logic [3:0] a, logic [W-1:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(logic [3:0] a);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 rdata", bus_rdata, 8'h00);
        rst_n = 1;
        repeat (3) @(negedge clk);
        rd(4'h1);
        chk("R5 all inputs", bus_rdata, 8'h3C);
        wr(4'h0, 8'hF0);
        chk("R2 dir write", pin_oe, 8'hF0);
        rd(4'h0);
        chk("R3 dir reads ones", bus_rdata, 8'hFF);
        @(negedge clk);
        chk("R10 idle after read", bus_rdata, 8'h00);
        wr(4'h1, 8'hA5);
        chk("R8 latch to pin", pin_out, 8'hA5);
        rd(4'h1);
        chk("R5 mixed read", bus_rdata, 8'hAC);
        // synchronizer depth: change pin together with back-to-back reads
        @(negedge clk); pin_in = 8'h03; bus_rd = 1; bus_addr = 4'h1;
        @(negedge clk); chk("R5 sync old 1", bus_rdata, 8'hAC);
        @(negedge clk); chk("R5 sync old 2", bus_rdata, 8'hAC);
        @(negedge clk); chk("R5 sync new", bus_rdata, 8'hA3);
        bus_rd = 0;
        wr(4'h0, 8'hFF);
        rd(4'h1);
        chk("R4 latch readback", bus_rdata, 8'hA5);
        @(negedge clk); alt_en = 8'h03; alt_data = 8'h02;
        @(negedge clk); chk("R8 alt select", pin_out, 8'hA6);
        alt_en = 0;
        @(negedge clk); sw_stby = 1;
        wr(4'h0, 8'h00);
        chk("R7 dir frozen", pin_oe, 8'hFF);
        wr(4'h1, 8'h00);
        chk("R7 latch frozen", pin_out, 8'hA5);
        rd(4'h1);
        chk("R7 read in standby", bus_rdata, 8'hA5);
        sw_stby = 0;
        rd(4'h7);
        chk("R9 unmapped read", bus_rdata, 8'h00);
        @(negedge clk); hw_stby = 1; bus_wr = 1; bus_addr = 4'h1; bus_wdata = 8'hFF;
        @(negedge clk); bus_wr = 0;
        chk("R6 oe cleared", pin_oe, 8'h00);
        chk("R6 latch cleared", pin_out, 8'h00);
        hw_stby = 0;
        rd(4'h1);
        chk("R6 read after clear", bus_rdata, 8'h03);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule